// File: doc/BRIEF.md
# Single-Wire Addressing Command Layer

This block is the byte-level state machine of a slave on a single-wire bus. Memory commands are accepted only after the slave has been addressed. A bit-level front end handles the line timing. For every time slot the front end gives one pulse, together with the level seen on the line, and it flags each bus reset. It also says whether that reset had standard-speed timing. The block assembles the first byte after a reset, least significant bit first, and decodes it as one of six addressing commands. It then sends or compares its 64-bit node identity, or runs the search exchange, so that many slaves can share the bus.

When addressing succeeds, the block raises a grant that unlocks the memory command stage. It keeps the grant until the next bus reset. Two of the commands also switch the slave to overdrive speed through a speed-select output. That speed holds for all later traffic until a reset with standard-speed timing. A failed compare, a lost search or an unknown command leaves the slave silent until the next bus reset. During a slot in which the slave must transmit, the block drives a transmit-enable and the bit to send.

Top module: `sw_addr_layer`

## Requirements
- R1: After the synchronous reset, mem_grant_o, tx_en_o and od_o are 0. Slots that arrive before the first bus reset are ignored.
- R2: The command byte is assembled least significant bit first. Eight slots carrying the bits of 0x33 in most-significant-first order therefore decode as 0xCC.
- R3: Command 0xCC (skip) raises mem_grant_o with no transmit slot. No slot is driven while the grant is held.
- R4: Command 0x33 (read) makes the next 64 slots transmit slots (tx_en_o=1), carrying id_i bit 0 first through bit 63. The grant is raised after the last of these slots.
- R5: Command 0x55 (match) compares the next 64 slot bits with id_i, bit 0 first. If all 64 bits are equal, mem_grant_o is raised.
- R6: In a match, one differing bit makes the slave idle. It gives no grant and drives no slot until the next bus reset, whatever slots follow.
- R7: Command 0xF0 (search) runs 64 rounds of three slots each. In each round the slave transmits id bit n, then transmits its complement, then reads a direction bit. When all 64 directions match, mem_grant_o is raised.
- R8: In a search, a direction bit that differs from the slave's own identity bit makes the slave idle until the next bus reset.
- R9: Command 0x3C (overdrive-skip) sets od_o to 1 and raises mem_grant_o.
- R10: Command 0x69 (overdrive-match) sets od_o to 1. A correct 64-bit identity that follows raises mem_grant_o.
- R11: A bus reset clears mem_grant_o and restarts command reception. With standard-speed timing (reset_std_i=1) it also clears od_o. A reset with overdrive timing leaves od_o unchanged.
- R12: Any other command byte makes the slave idle. It gives no grant and drives no slot until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: the front end detected a bus reset |
| reset_std_i | input | 1 | Qualifies bus_reset_i: the reset had standard-speed timing |
| slot_i | input | 1 | One-cycle pulse per completed time slot |
| slot_bit_i | input | 1 | Line level sampled in that slot |
| id_i | input | 64 | Node identity, bit 0 sent first |
| tx_en_o | output | 1 | The current slot is driven by this slave |
| tx_bit_o | output | 1 | Bit to drive when tx_en_o is 1 |
| od_o | output | 1 | Speed select: 1 selects overdrive timing |
| mem_grant_o | output | 1 | Addressing succeeded; memory commands may follow |

## Verification
On every cycle, the assertions check the rules that tie the outputs to the reset and slot inputs. A bus reset drops the grant. A standard-speed reset clears the speed select, and an overdrive-timed reset keeps it. The grant and overdrive rise only one or two cycles after a slot. The slave never transmits while granted, and the transmitted bit changes only at slot or reset boundaries. Only the bench scenarios can show that the command codes decode correctly, that identity bits go out in order, that the complement comes out during search, and that a failed match, a lost search or an unknown command leaves the slave silent until the next reset.

// File: rtl/sw_addr_pkg.sv
`timescale 1ns/1ps
package sw_addr_pkg;

  localparam int unsigned CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_READ     = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] OP_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_LOCK,   // silent until next bus reset
    ST_CMD,    // collecting the addressing command byte
    ST_SEND,   // transmitting identity
    ST_CMP,    // comparing received identity
    ST_S_BIT,  // search: send identity bit
    ST_S_INV,  // search: send complement
    ST_S_DIR,  // search: read direction
    ST_OPEN    // addressed; memory stage unlocked
  } addr_st_t;

endpackage

// File: rtl/sw_byte_rx.sv
`timescale 1ns/1ps
module sw_byte_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shifted;

  // first bit on the wire ends up in bit 0
  assign shifted = {bit_in, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg    <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_o   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (bit_vld) begin
        shreg <= shifted;
        if (cnt == CNT_LAST) begin
          cnt      <= '0;
          byte_o   <= shifted;
          byte_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sw_speed_ctl.sv
`timescale 1ns/1ps
module sw_speed_ctl (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset,
  input  logic reset_std,
  input  logic od_set,
  output logic od_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      od_o <= 1'b0;
    end else if (bus_reset && reset_std) begin
      od_o <= 1'b0;
    end else if (od_set) begin
      od_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sw_addr_fsm.sv
`timescale 1ns/1ps
module sw_addr_fsm
  import sw_addr_pkg::*;
#(
  parameter int unsigned ID_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic             slot,
  input  logic             slot_bit,
  input  logic [ID_W-1:0]  id,
  input  logic             byte_vld,
  input  logic [CMD_W-1:0] byte_in,
  output logic             rx_en,
  output logic             od_set,
  output logic             tx_en,
  output logic             tx_bit,
  output logic             grant
);
  localparam int unsigned IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  addr_st_t         st, nst;
  logic [IDX_W-1:0] idx, nidx;
  logic             last;
  logic             own_bit;

  assign last    = (idx == IDX_LAST);
  assign own_bit = id[idx];
  assign rx_en   = (st == ST_CMD) && slot && !bus_reset;

  always_comb begin
    nst    = st;
    nidx   = idx;
    od_set = 1'b0;
    if (bus_reset) begin
      nst  = ST_CMD;
      nidx = '0;
    end else begin
      unique case (st)
        ST_CMD: begin
          if (byte_vld) begin
            nidx = '0;
            case (byte_in)
              OP_READ:     nst = ST_SEND;
              OP_MATCH:    nst = ST_CMP;
              OP_SEARCH:   nst = ST_S_BIT;
              OP_SKIP:     nst = ST_OPEN;
              OP_OD_SKIP:  begin nst = ST_OPEN; od_set = 1'b1; end
              OP_OD_MATCH: begin nst = ST_CMP;  od_set = 1'b1; end
              default:     nst = ST_LOCK;
            endcase
          end
        end
        ST_SEND: begin
          if (slot) begin
            if (last) nst = ST_OPEN;
            else      nidx = idx + 1'b1;
          end
        end
        ST_CMP: begin
          if (slot) begin
            if (slot_bit != own_bit) nst = ST_LOCK;
            else if (last)           nst = ST_OPEN;
            else                     nidx = idx + 1'b1;
          end
        end
        ST_S_BIT: if (slot) nst = ST_S_INV;
        ST_S_INV: if (slot) nst = ST_S_DIR;
        ST_S_DIR: begin
          if (slot) begin
            if (slot_bit != own_bit) nst = ST_LOCK;
            else if (last)           nst = ST_OPEN;
            else begin
              nst  = ST_S_BIT;
              nidx = idx + 1'b1;
            end
          end
        end
        ST_LOCK, ST_OPEN: ;
        default: nst = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_LOCK;
      idx    <= '0;
      tx_en  <= 1'b0;
      tx_bit <= 1'b0;
      grant  <= 1'b0;
    end else begin
      st     <= nst;
      idx    <= nidx;
      tx_en  <= (nst == ST_SEND) || (nst == ST_S_BIT) || (nst == ST_S_INV);
      tx_bit <= (nst == ST_S_INV) ? ~id[nidx] : id[nidx];
      grant  <= (nst == ST_OPEN);
    end
  end
endmodule

// File: rtl/sw_addr_layer.sv
`timescale 1ns/1ps
module sw_addr_layer
  import sw_addr_pkg::*;
#(
  parameter int unsigned ID_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_reset_i,
  input  logic            reset_std_i,
  input  logic            slot_i,
  input  logic            slot_bit_i,
  input  logic [ID_W-1:0] id_i,
  output logic            tx_en_o,
  output logic            tx_bit_o,
  output logic            od_o,
  output logic            mem_grant_o
);
  logic             rx_en;
  logic             byte_vld;
  logic [CMD_W-1:0] cmd_byte;
  logic             od_set;

  sw_byte_rx #(.BYTE_W(CMD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clr      (bus_reset_i),
    .bit_vld  (rx_en),
    .bit_in   (slot_bit_i),
    .byte_vld (byte_vld),
    .byte_o   (cmd_byte)
  );

  sw_addr_fsm #(.ID_W(ID_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bus_reset(bus_reset_i),
    .slot     (slot_i),
    .slot_bit (slot_bit_i),
    .id       (id_i),
    .byte_vld (byte_vld),
    .byte_in  (cmd_byte),
    .rx_en    (rx_en),
    .od_set   (od_set),
    .tx_en    (tx_en_o),
    .tx_bit   (tx_bit_o),
    .grant    (mem_grant_o)
  );

  sw_speed_ctl u_speed (
    .clk      (clk),
    .rst      (rst),
    .bus_reset(bus_reset_i),
    .reset_std(reset_std_i),
    .od_set   (od_set),
    .od_o     (od_o)
  );
endmodule

// File: rtl/sw_addr_layer_chk.sv
`timescale 1ns/1ps
module sw_addr_layer_chk (
  input logic clk,
  input logic rst,
  input logic bus_reset_i,
  input logic reset_std_i,
  input logic slot_i,
  input logic tx_en_o,
  input logic tx_bit_o,
  input logic od_o,
  input logic mem_grant_o
);
  // R11: any bus reset withdraws the grant
  a_r11_reset_drops_grant: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> !mem_grant_o);

  // R11: standard-speed reset returns to standard speed
  a_r11_std_reset_slow: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i && reset_std_i) |=> !od_o);

  // R11: overdrive-timed reset keeps overdrive
  a_r11_od_reset_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i && !reset_std_i && od_o) |=> od_o);

  // R9/R10: overdrive is entered only after a command byte completes
  a_r9_od_after_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(od_o) |-> $past(slot_i, 2));

  // R5: the grant rises only right after a slot ends addressing
  a_r5_grant_after_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_grant_o) |-> ($past(slot_i) || $past(slot_i, 2)));

  // R3: a granted slave never drives the line
  a_r3_grant_silent: assert property (@(posedge clk) disable iff (rst)
    mem_grant_o |-> !tx_en_o);

  // R4: the transmitted bit only moves at slot or reset boundaries
  a_r4_tx_steady: assert property (@(posedge clk) disable iff (rst)
    (tx_en_o && $past(tx_en_o) && !$past(slot_i) && !$past(bus_reset_i))
      |-> $stable(tx_bit_o));
endmodule

bind sw_addr_layer sw_addr_layer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_reset_i(bus_reset_i),
  .reset_std_i(reset_std_i),
  .slot_i     (slot_i),
  .tx_en_o    (tx_en_o),
  .tx_bit_o   (tx_bit_o),
  .od_o       (od_o),
  .mem_grant_o(mem_grant_o)
);

// File: tb/sw_addr_layer_test.sv
`timescale 1ns/1ps
module sw_addr_layer_test;
  localparam int unsigned ID_W = 64;
  localparam logic [ID_W-1:0] NODE_ID = 64'hB4_6E21C97D0358_2D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset_i = 1'b0;
  logic reset_std_i = 1'b0;
  logic slot_i = 1'b0;
  logic slot_bit_i = 1'b0;
  logic tx_en_o, tx_bit_o, od_o, mem_grant_o;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sw_addr_layer #(.ID_W(ID_W)) uut (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .reset_std_i(reset_std_i),
    .slot_i(slot_i), .slot_bit_i(slot_bit_i), .id_i(NODE_ID),
    .tx_en_o(tx_en_o), .tx_bit_o(tx_bit_o), .od_o(od_o), .mem_grant_o(mem_grant_o)
  );

  // monitor: every slot pops one expected {tx_en, tx_bit}
  always @(negedge clk) begin
    if (slot_i && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (tx_en_o !== e[1] || (e[1] && tx_bit_o !== e[0])) begin
        fails++;
        $display("FAIL %s slot: tx_en=%b tx_bit=%b expected tx_en=%b tx_bit=%b",
                 t, tx_en_o, tx_bit_o, e[1], e[0]);
      end
    end
  end

  // driver: one slot, pushing what the slave should drive in it
  task automatic do_slot(input logic b, input logic xen, input logic xbit);
    exp_q.push_back({xen, xbit});
    tag_q.push_back(cur_tag);
    @(posedge clk); #1;
    slot_i = 1'b1; slot_bit_i = b;
    @(posedge clk); #1;
    slot_i = 1'b0; slot_bit_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) do_slot(b[i], 1'b0, 1'b0);
  endtask

  task automatic bus_rst(input logic std);
    @(posedge clk); #1;
    bus_reset_i = 1'b1; reset_std_i = std;
    @(posedge clk); #1;
    bus_reset_i = 1'b0; reset_std_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic chk(input logic g_exp, input logic od_exp, input logic en_exp,
                     input string t);
    @(posedge clk); #2;
    checks++;
    if (mem_grant_o !== g_exp || od_o !== od_exp || tx_en_o !== en_exp) begin
      fails++;
      $display("FAIL %s: grant=%b od=%b tx_en=%b expected grant=%b od=%b tx_en=%b",
               t, mem_grant_o, od_o, tx_en_o, g_exp, od_exp, en_exp);
    end
  endtask

  task automatic send_id(input logic [ID_W-1:0] v);
    for (int i = 0; i < ID_W; i++) do_slot(v[i], 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state and no action before the first bus reset
    chk(1'b0, 1'b0, 1'b0, "R1 reset state");
    cur_tag = "R1";
    send_byte(8'hCC);
    chk(1'b0, 1'b0, 1'b0, "R1 ignored before bus reset");

    // R3: skip
    bus_rst(1'b1);
    cur_tag = "R3";
    send_byte(8'hCC);
    chk(1'b1, 1'b0, 1'b0, "R3 skip grants");
    for (int i = 0; i < 3; i++) do_slot(1'b1, 1'b0, 1'b0);

    // R2: bits of 0x33 sent MSB first are seen as 0xCC
    bus_rst(1'b1);
    chk(1'b0, 1'b0, 1'b0, "R11 reset drops grant");
    cur_tag = "R2";
    for (int i = 7; i >= 0; i--) do_slot(OP33(i), 1'b0, 1'b0);
    chk(1'b1, 1'b0, 1'b0, "R2 lsb-first decode");

    // R4: read identity
    bus_rst(1'b1);
    cur_tag = "R4";
    send_byte(8'h33);
    chk(1'b0, 1'b0, 1'b1, "R4 transmit armed");
    for (int i = 0; i < ID_W; i++) do_slot(1'b1, 1'b1, NODE_ID[i]);
    chk(1'b1, 1'b0, 1'b0, "R4 grant after read");

    // R5: match identity
    bus_rst(1'b1);
    cur_tag = "R5";
    send_byte(8'h55);
    send_id(NODE_ID);
    chk(1'b1, 1'b0, 1'b0, "R5 match grants");

    // R6: mismatch at bit 40
    bus_rst(1'b1);
    cur_tag = "R6";
    send_byte(8'h55);
    send_id(NODE_ID ^ (64'd1 << 40));
    chk(1'b0, 1'b0, 1'b0, "R6 mismatch no grant");
    send_byte(8'h33);
    for (int i = 0; i < 4; i++) do_slot(1'b1, 1'b0, 1'b0);
    send_byte(8'hCC);
    chk(1'b0, 1'b0, 1'b0, "R6 stays silent");

    // R7: full search
    bus_rst(1'b1);
    cur_tag = "R7";
    send_byte(8'hF0);
    for (int i = 0; i < ID_W; i++) begin
      do_slot(1'b1, 1'b1, NODE_ID[i]);
      do_slot(1'b1, 1'b1, ~NODE_ID[i]);
      do_slot(NODE_ID[i], 1'b0, 1'b0);
    end
    chk(1'b1, 1'b0, 1'b0, "R7 search grants");

    // R8: lost search at bit 10
    bus_rst(1'b1);
    cur_tag = "R8";
    send_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      do_slot(1'b1, 1'b1, NODE_ID[i]);
      do_slot(1'b1, 1'b1, ~NODE_ID[i]);
      do_slot((i == 10) ? ~NODE_ID[i] : NODE_ID[i], 1'b0, 1'b0);
    end
    for (int i = 0; i < 3; i++) do_slot(1'b1, 1'b0, 1'b0);
    chk(1'b0, 1'b0, 1'b0, "R8 dropped out");

    // R9: overdrive skip, then R11 speed handling
    bus_rst(1'b1);
    cur_tag = "R9";
    send_byte(8'h3C);
    chk(1'b1, 1'b1, 1'b0, "R9 overdrive skip");
    bus_rst(1'b0);
    chk(1'b0, 1'b1, 1'b0, "R11 overdrive reset keeps speed");
    cur_tag = "R11";
    send_byte(8'hCC);
    chk(1'b1, 1'b1, 1'b0, "R11 skip in overdrive");
    bus_rst(1'b1);
    chk(1'b0, 1'b0, 1'b0, "R11 standard reset slows");

    // R10: overdrive match
    cur_tag = "R10";
    send_byte(8'h69);
    chk(1'b0, 1'b1, 1'b0, "R10 overdrive entered");
    send_id(NODE_ID);
    chk(1'b1, 1'b1, 1'b0, "R10 match grants");
    bus_rst(1'b1);

    // R12: unknown command
    cur_tag = "R12";
    send_byte(8'hA5);
    chk(1'b0, 1'b0, 1'b0, "R12 unknown no grant");
    send_byte(8'h33);
    for (int i = 0; i < 4; i++) do_slot(1'b1, 1'b0, 1'b0);
    send_byte(8'h3C);
    chk(1'b0, 1'b0, 1'b0, "R12 stays silent");
    bus_rst(1'b1);
    send_byte(8'hCC);
    chk(1'b1, 1'b0, 1'b0, "R12 recovers after reset");

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic OP33(input int i);
    logic [7:0] v;
    v = 8'h33;
    return v[i];
  endfunction
endmodule